// File: doc/BRIEF.md
# Single-Cycle Six-Operation Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock period. It decodes six operations: register add, register subtract, OR with a zero-extended immediate, word load, word store, and compare-and-branch on equality. Inside the core are the program counter and its next-address logic, a 32-entry register file with two combinational read ports and one write port, the immediate extender, the ALU, the operand and writeback selectors, and the decoder.

Instruction and data memory sit outside the core. Both are word arrays with a combinational read and a write on the clock. The core presents a byte address, and the memories index words with address bits [31:2].

Every state element, including register-file writes and the data-memory write strobe timing, acts on the falling clock edge. Fields are fixed: opcode [31:26], first source [25:21], second source / immediate destination [20:16], register destination [15:11], function [5:0], immediate [15:0].

Top module: `ucc_core`

## Requirements
- R1: A synchronous active-high reset, sampled on the falling edge, sets the PC to RESET_PC (default 0). While reset is high, no register-file write and no data-memory write strobe happens.
- R2: Opcode 000000 with function 100001 writes the register at [15:11] with the sum of the two source registers, modulo 2^32.
- R3: Opcode 000000 with function 100011 writes the register at [15:11] with the first source minus the second, modulo 2^32.
- R4: Opcode 001101 writes the register at [20:16] with the first source ORed with the immediate, zero-extended to 32 bits.
- R5: Opcode 100011 writes the register at [20:16] with the data word read at the address first source + sign-extended immediate.
- R6: Opcode 101011 raises the data write strobe, drives the address first source + sign-extended immediate and the data of the register at [20:16], and writes no register.
- R7: Opcode 000100 compares the two sources by an ALU subtraction with a zero result. When they are equal, the next PC is PC + 4 + (sign-extended immediate << 2), and the offset may be negative. Otherwise the next PC is PC + 4.
- R8: Every instruction other than a taken branch advances the PC by 4.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode, and opcode 000000 with any other function code, changes no register and no memory, and only advances the PC by 4.
- R11: State changes only on the falling edge. Between a rising edge and the following falling edge, the PC is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word read at imem_addr |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Data to be written by a store |
| dmem_we | output | 1 | Data write strobe, taken on the falling edge |
| dmem_rdata | input | 32 | Data word read at dmem_addr |

## Verification
The bench builds the core with its defaults: 32 registers, 32-bit words and a reset PC of 0. With these values the hard-wired zero register, 32-bit wrap-around in add and subtract, a negative load offset and a backward branch that lands on itself can all be reached. A short program exercises each operation. Every store and every PC value is compared against a queue of expected values worked out from the instruction semantics. Garbage opcodes and unknown function codes sit between stores that would expose any stray write.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

  localparam int WORD_W  = 32;
  localparam int REG_CNT = 32;
  localparam int REG_AW  = $clog2(REG_CNT);
  localparam int IMM_W   = 16;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] FN_ADD   = 6'b100001;
  localparam logic [5:0] FN_SUB   = 6'b100011;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;
    logic    b_imm;
    logic    zext;
    logic    wb_mem;
    logic    mem_we;
    logic    is_beq;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] ext_imm(input logic [IMM_W-1:0] imm,
                                                input logic zext);
    logic fill;
    fill = imm[IMM_W-1] & ~zext;
    return {{(WORD_W-IMM_W){fill}}, imm};
  endfunction

  function automatic logic [WORD_W-1:0] alu_calc(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input alu_op_e op);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] br_target(input logic [WORD_W-1:0] pc4,
                                                  input logic [IMM_W-1:0] imm);
    return pc4 + {{(WORD_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  endfunction

endpackage

// File: rtl/ucc_decode.sv
module ucc_decode
  import ucc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{rf_we: 1'b0, dst_rd: 1'b0, b_imm: 1'b0, zext: 1'b0,
             wb_mem: 1'b0, mem_we: 1'b0, is_beq: 1'b0, alu_op: ALU_ADD};
    case (op)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        if (funct == FN_ADD) begin
          ctrl.rf_we  = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.rf_we  = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.rf_we  = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.zext   = 1'b1;
        ctrl.alu_op = ALU_OR;
      end
      OP_LOAD: begin
        ctrl.rf_we  = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.wb_mem = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_we = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_beq = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ucc_regfile.sv
module ucc_regfile
  import ucc_pkg::*;
#(
  parameter int DW   = WORD_W,
  parameter int NREG = REG_CNT,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [NREG-1:0][DW-1:0] bank;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else begin : g_live
      logic [DW-1:0] q;
      always_ff @(negedge clk) begin
        if (we && waddr == AW'(i)) q <= wdata;
      end
      assign bank[i] = q;
    end
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/ucc_alu.sv
module ucc_alu
  import ucc_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);

  assign y    = alu_calc(a, b, op);
  assign zero = (y == '0);

endmodule

// File: rtl/ucc_fetch.sv
module ucc_fetch
  import ucc_pkg::*;
#(
  parameter int DW                = WORD_W,
  parameter logic [DW-1:0] RST_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_branch,
  input  logic [IMM_W-1:0] imm,
  output logic [DW-1:0]    pc,
  output logic [DW-1:0]    pc_next
);

  logic [DW-1:0] pc_plus4;

  assign pc_plus4 = pc + DW'(4);
  assign pc_next  = take_branch ? br_target(pc_plus4, imm) : pc_plus4;

  always_ff @(negedge clk) begin
    if (rst) pc <= RST_PC;
    else     pc <= pc_next;
  end

endmodule

// File: rtl/ucc_core.sv
module ucc_core
  import ucc_pkg::*;
#(
  parameter int DW                  = WORD_W,
  parameter int NREG                = REG_CNT,
  parameter logic [DW-1:0] RESET_PC = '0,
  localparam int AW                 = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] imem_addr,
  input  logic [DW-1:0] imem_rdata,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [DW-1:0] dmem_rdata
);

  logic [5:0]       op_f;
  logic [5:0]       fn_f;
  logic [AW-1:0]    rs_f;
  logic [AW-1:0]    rt_f;
  logic [AW-1:0]    rd_f;
  logic [IMM_W-1:0] imm_f;

  assign op_f  = imem_rdata[31:26];
  assign rs_f  = imem_rdata[21 +: AW];
  assign rt_f  = imem_rdata[16 +: AW];
  assign rd_f  = imem_rdata[11 +: AW];
  assign fn_f  = imem_rdata[5:0];
  assign imm_f = imem_rdata[IMM_W-1:0];

  ctrl_t         ctrl;
  logic [DW-1:0] pc_q;
  logic [DW-1:0] pc_nx;
  logic [DW-1:0] rs_val;
  logic [DW-1:0] rt_val;
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] alu_b;
  logic [DW-1:0] alu_y;
  logic          alu_zero;
  logic          take_branch;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;
  logic          mem_we;

  ucc_decode u_dec (
    .op    (op_f),
    .funct (fn_f),
    .ctrl  (ctrl)
  );

  ucc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_f),
    .raddr_b (rt_f),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_ext = DW'(ext_imm(imm_f, ctrl.zext));
  assign alu_b   = ctrl.b_imm ? imm_ext : rt_val;

  ucc_alu #(.DW(DW)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign take_branch = ctrl.is_beq & alu_zero;

  ucc_fetch #(.DW(DW), .RST_PC(RESET_PC)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .take_branch (take_branch),
    .imm         (imm_f),
    .pc          (pc_q),
    .pc_next     (pc_nx)
  );

  assign rf_we    = ctrl.rf_we & ~rst;
  assign rf_waddr = ctrl.dst_rd ? rd_f : rt_f;
  assign rf_wdata = ctrl.wb_mem ? dmem_rdata : alu_y;
  assign mem_we   = ctrl.mem_we & ~rst;

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = mem_we;

endmodule

// File: rtl/ucc_core_chk.sv
module ucc_core_chk
  import ucc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] reset_pc,
  input logic [WORD_W-1:0] pc,
  input logic              take_branch,
  input logic [5:0]        op,
  input logic [15:0]       imm,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr,
  input logic              mem_we,
  input logic [REG_AW-1:0] rs_addr,
  input logic [WORD_W-1:0] rs_data
);

  p_reset_pc_r1: assert property (@(negedge clk)
    rst |=> pc == reset_pc);

  p_no_write_in_reset_r1: assert property (@(negedge clk)
    rst |-> !rf_we && !mem_we);

  p_pc_step_r8: assert property (@(negedge clk) disable iff (rst)
    !take_branch |=> pc == $past(pc) + 32'd4);

  p_taken_target_r7: assert property (@(negedge clk) disable iff (rst)
    take_branch |=> pc == $past(pc) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00});

  p_branch_only_beq_r7: assert property (@(negedge clk) disable iff (rst)
    take_branch |-> op == OP_BEQ);

  p_store_no_wb_r6: assert property (@(negedge clk) disable iff (rst)
    mem_we |-> !rf_we);

  p_zero_reads_zero_r9: assert property (@(negedge clk) disable iff (rst)
    rs_addr == '0 |-> rs_data == '0);

  p_one_effect_r10: assert property (@(negedge clk) disable iff (rst)
    $onehot0({rf_we, mem_we, take_branch}));

endmodule

bind ucc_core ucc_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reset_pc    (RESET_PC),
  .pc          (pc_q),
  .take_branch (take_branch),
  .op          (op_f),
  .imm         (imm_f),
  .rf_we       (rf_we),
  .rf_waddr    (rf_waddr),
  .mem_we      (mem_we),
  .rs_addr     (rs_f),
  .rs_data     (rs_val)
);

// File: tb/ucc_core_tb_top.sv
module ucc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  always #10 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(negedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  ucc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    running = 0;
  bit    done = 0;

  logic [31:0] exp_pc_q [$];
  string       pc_tag_q [$];
  logic [63:0] exp_st_q [$];
  string       st_tag_q [$];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_pc(logic [31:0] pc, string tag);
    exp_pc_q.push_back(pc);
    pc_tag_q.push_back(tag);
  endtask

  task automatic push_st(logic [31:0] a, logic [31:0] d, string tag);
    exp_st_q.push_back({a, d});
    st_tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (running) begin
      if (exp_pc_q.size() > 0) begin
        check(pc_tag_q.pop_front(), imem_addr, exp_pc_q.pop_front());
      end
      if (dmem_we) begin
        if (exp_st_q.size() > 0) begin
          logic [63:0] e;
          string t;
          e = exp_st_q.pop_front();
          t = st_tag_q.pop_front();
          check({t, " addr"}, dmem_addr, e[63:32]);
          check({t, " data"}, dmem_wdata, e[31:0]);
        end else begin
          check("R10 unexpected store", dmem_addr, 32'hxxxxxxxx);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r1, r2, r3, r4, r7, p0;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[7] = 32'hCAFEBABE;

    imem[0]  = enc_i(6'b001101, 0, 1, 16'h1234);
    imem[1]  = enc_i(6'b001101, 0, 2, 16'hF00F);
    imem[2]  = enc_r(1, 2, 3, 6'b100001);
    imem[3]  = enc_r(1, 2, 4, 6'b100011);
    imem[4]  = enc_i(6'b101011, 0, 3, 16'd0);
    imem[5]  = enc_i(6'b101011, 0, 4, 16'd4);
    imem[6]  = enc_i(6'b001101, 0, 0, 16'h0055);
    imem[7]  = enc_i(6'b101011, 0, 0, 16'd8);
    imem[8]  = enc_i(6'b001101, 0, 5, 16'h0020);
    imem[9]  = enc_i(6'b100011, 5, 6, 16'hFFFC);
    imem[10] = enc_i(6'b101011, 0, 6, 16'd12);
    imem[11] = enc_i(6'b000100, 1, 2, 16'd5);
    imem[12] = enc_i(6'b101011, 0, 1, 16'd16);
    imem[13] = enc_i(6'b000100, 1, 1, 16'd2);
    imem[14] = enc_i(6'b101011, 0, 2, 16'd20);
    imem[15] = enc_i(6'b101011, 0, 2, 16'd20);
    imem[16] = 32'hFFFFFFFF;
    imem[17] = enc_r(2, 3, 1, 6'b100000);
    imem[18] = enc_i(6'b101011, 0, 1, 16'd24);
    imem[19] = enc_r(4, 4, 7, 6'b100001);
    imem[20] = enc_i(6'b101011, 5, 7, 16'd28);
    imem[21] = enc_i(6'b000100, 0, 0, 16'hFFFF);

    r1 = 32'h0000_1234;
    r2 = 32'h0000_F00F;
    r3 = r1 + r2;
    r4 = r1 - r2;
    r7 = r4 + r4;

    for (int w = 0; w <= 13; w++) push_pc(32'(w * 4), (w == 12) ? "R7 not-taken" : "R8");
    push_pc(32'd64, "R7 taken");
    for (int w = 17; w <= 21; w++) push_pc(32'(w * 4), "R8");
    for (int k = 0; k < 3; k++) push_pc(32'd84, "R7 backward");

    push_st(32'd0,  r3, "R2,R4 add");
    push_st(32'd4,  r4, "R3 sub");
    push_st(32'd8,  32'd0, "R9 zero reg");
    push_st(32'd12, 32'hCAFEBABE, "R5 load");
    push_st(32'd16, r1, "R6,R7 fallthrough store");
    push_st(32'd24, r1, "R10 ignored ops");
    push_st(32'd60, r7, "R2 wrap");

    repeat (3) @(posedge clk);
    #2;
    check("R1 reset pc", imem_addr, 32'd0);
    check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    @(negedge clk);
    #2;
    check("R1 pc held", imem_addr, 32'd0);
    rst = 1'b0;
    running = 1'b1;

    @(posedge clk);
    #1;
    p0 = imem_addr;
    #8;
    check("R11 pc stable before falling edge", imem_addr, p0);

    repeat (23) @(posedge clk);
    #1;
    running = 1'b0;
    check("R6 all stores seen", 32'(exp_st_q.size()), 32'd0);
    check("R8 all pcs seen", 32'(exp_pc_q.size()), 32'd0);
    finish_run();
  end

endmodule